// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Classification

This block receives asynchronous serial frames from a single line. The line is sampled 16 times per bit period, paced by an external sample-tick strobe. Each frame has one start bit, 8 or 9 data bits sent least significant bit first, and one stop bit. When parity is on, the last data bit is the parity bit. A received word goes into a holding register and raises a data-full flag. Framing and parity error flags describe that same word. A sticky break flag reports a long run of low bits.

When break detection is enabled, the receiver counts consecutive low bit decisions. It sorts a break into one of two cases:

- **Start-aligned break.** The run begins at the start bit. The frame is dropped, and the data register, data-full flag and error flags are left untouched.
- **Mid-frame break.** The run begins inside the frame. The receiver stores the partial word at the stop position, raises the framing error and, where it applies, the parity error.

In both cases the break flag is raised once the run reaches the frame length in bits. After any frame whose stop bit is low, the receiver waits for the line to go high again before it looks for a new start bit.

The controller has five states:

| State | Purpose |
|---|---|
| `ST_IDLE` | Hunting for a start bit |
| `ST_START` | Qualifying the start bit |
| `ST_DATA` | Shifting in data bits |
| `ST_STOP` | Checking the stop bit |
| `ST_LINE_WAIT` | Waiting for the line to return high |

Transitions:

- `ST_IDLE` goes to `ST_START` on a low sample.
- `ST_START` goes to `ST_DATA` when the centre vote is low. It returns to `ST_IDLE` when the vote is high (glitch rejected).
- `ST_DATA` goes to `ST_STOP` after the last data bit.
- `ST_STOP` goes to `ST_IDLE` on a high stop bit, or to `ST_LINE_WAIT` on a low one.
- `ST_LINE_WAIT` goes to `ST_IDLE` on the first high bit decision.

Top module: `uart_brk_rx`

## Requirements
- R1: The line idles high. A start bit is accepted only when the majority of samples 7, 8 and 9 of the 16 samples in its bit period is low. A low pulse shorter than that is ignored, and no word is stored.
- R2: Data bits are taken least significant bit first. There are 9 of them when `nine_bit_sel`=1 and 8 when it is 0 (then `rx_data[8]`=0). Each bit is the majority of samples 7, 8 and 9. A stored word sets `rx_full`, and `rd_ack` clears it.
- R3: A high stop bit stores the word with `frm_err`=0. A low stop bit that is not a start-aligned break stores the word with `frm_err`=1.
- R4: With `par_en`=1, `par_err` is set for a stored word when the count of ones over all received data bits (parity bit included) is odd with `par_odd`=0, or even with `par_odd`=1. With `par_en`=0, `par_err` is 0.
- R5: With `brk_en`=1, a frame whose start, data and stop bits are all low stores nothing. `rx_data`, `rx_full`, `frm_err` and `par_err` keep their values, and `brk_flag` is set.
- R6: With `brk_en`=1, a zero run that begins inside a frame stores the partial word with `frm_err`=1 and the computed `par_err`. `brk_flag` is set when the run reaches the threshold, and not before.
- R7: With `brk_en`=0, an all-low frame is stored as 0x000 with `frm_err`=1 and its parity result, and `brk_flag` stays 0.
- R8: `brk_flag` stays set until `brk_clr` is pulsed. It is not set again by the same low run. No new start bit is searched for until the line has gone high.
- R9: The break threshold is 10 consecutive low bits in 8-bit format and 11 in 9-bit format.
- R10: After reset, `rx_full`, `frm_err`, `par_err` and `brk_flag` are 0 and `rx_data` is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_tick | input | 1 | One pulse per sample; 16 per bit |
| rxd | input | 1 | Serial line, idle high |
| nine_bit_sel | input | 1 | 1 = 9 data bits, 0 = 8 |
| par_en | input | 1 | Last data bit is parity |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| brk_en | input | 1 | Enable break detection |
| brk_clr | input | 1 | Clears the break flag |
| rd_ack | input | 1 | Clears the data-full flag |
| rx_data | output | 9 | Last stored word |
| rx_full | output | 1 | Word available |
| frm_err | output | 1 | Stop bit of stored word was low |
| par_err | output | 1 | Parity check of stored word failed |
| brk_flag | output | 1 | Break detected (sticky) |

## Verification
The bench targets the boundary between a break and a framing error. It sends runs one bit short of the threshold and runs exactly at it, in both formats. A receiver with an off-by-one counter, or one that ignores the format, would flag a break too early or miss it. A start-aligned break must leave the previous word and its error flags in place; a design that wrote anyway would show 0x000 or a cleared error. The bench also holds the line low well past a break and pulses the clear. A design that re-armed while the line was low would raise the flag again or store a phantom word. A short glitch checks that the centre vote rejects false starts.

// File: rtl/uart_brk_rx_pkg.sv
package uart_brk_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_LINE_WAIT
    } rx_state_e;
endpackage

// File: rtl/rx_maj_voter.sv
// Synchronises the line and votes over the last three samples.
module rx_maj_voter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_tick,
    input  logic rxd,
    output logic rx_s,
    output logic maj
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [1:0]             hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
        end
    end

    assign rx_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= 2'b11;
        end else if (samp_tick) begin
            hist_q <= {hist_q[0], rx_s};
        end
    end

    // two stored samples plus the one being taken now
    assign maj = (hist_q[1] & hist_q[0]) | (hist_q[1] & rx_s) | (hist_q[0] & rx_s);
endmodule

// File: rtl/rx_zero_run.sv
// Saturating count of consecutive low bit decisions.
module rx_zero_run #(
    parameter int ZW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          bit_valid,
    input  logic          bit_val,
    output logic [ZW-1:0] cnt_inc
);
    logic [ZW-1:0] cnt;

    assign cnt_inc = (cnt == '1) ? cnt : cnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (bit_valid) begin
            cnt <= bit_val ? '0 : cnt_inc;
        end
    end

    // R9
    zero_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && bit_valid && !bit_val && cnt == '1) |=> (cnt == '1));
endmodule

// File: rtl/rx_par_chk.sv
module rx_par_chk #(
    parameter int DW = 9
) (
    input  logic [DW-1:0] bits,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          perr
);
    assign perr = par_en && ((^bits) != par_odd);
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
    import uart_brk_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          samp_tick,
    input  logic          rxd,
    input  logic          nine_bit_sel,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          brk_en,
    input  logic          brk_clr,
    input  logic          rd_ack,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          frm_err,
    output logic          par_err,
    output logic          brk_flag
);
    localparam int PW     = $clog2(OVS);
    localparam int BIDX_W = $clog2(DW);
    localparam int ZW     = $clog2(DW + 3) + 1;
    localparam int DEC_PH = OVS / 2 + 1;

    rx_state_e st, nxt;

    logic [PW-1:0]     ph, ph_nxt;
    logic [BIDX_W-1:0] bit_idx, last_idx;
    logic [DW-1:0]     shreg;
    logic [ZW-1:0]     cnt_inc, thr;
    logic              rx_s, maj, dec, brk_hit, perr, store, brk_set;

    rx_maj_voter #(.SYNC_STAGES(2)) u_vote (
        .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick),
        .rxd(rxd), .rx_s(rx_s), .maj(maj)
    );

    rx_zero_run #(.ZW(ZW)) u_zrun (
        .clk(clk), .rst_n(rst_n), .clr(st == ST_IDLE),
        .bit_valid(dec), .bit_val(maj), .cnt_inc(cnt_inc)
    );

    rx_par_chk #(.DW(DW)) u_par (
        .bits(shreg), .par_en(par_en), .par_odd(par_odd), .perr(perr)
    );

    assign last_idx = nine_bit_sel ? BIDX_W'(DW - 1) : BIDX_W'(DW - 2);
    assign thr      = nine_bit_sel ? ZW'(DW + 2) : ZW'(DW + 1);
    assign ph_nxt   = (ph == PW'(OVS - 1)) ? '0 : ph + 1'b1;
    assign dec      = samp_tick && (ph == PW'(DEC_PH)) && (st != ST_IDLE);
    assign brk_hit  = dec && !maj && (cnt_inc == thr);
    assign store    = (st == ST_STOP) && dec && !(brk_en && brk_hit);
    assign brk_set  = brk_en && brk_hit && ((st == ST_STOP) || (st == ST_LINE_WAIT));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // transitions
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:      if (samp_tick && !rx_s) nxt = ST_START;
            ST_START:     if (dec) nxt = maj ? ST_IDLE : ST_DATA;
            ST_DATA:      if (dec && bit_idx == last_idx) nxt = ST_STOP;
            ST_STOP:      if (dec) nxt = maj ? ST_IDLE : ST_LINE_WAIT;
            ST_LINE_WAIT: if (dec && maj) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph       <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            rx_data  <= '0;
            rx_full  <= 1'b0;
            frm_err  <= 1'b0;
            par_err  <= 1'b0;
            brk_flag <= 1'b0;
        end else begin
            if (st == ST_IDLE) begin
                if (samp_tick && !rx_s) ph <= PW'(1);
            end else if (samp_tick) begin
                ph <= ph_nxt;
            end
            if (st == ST_START && dec) begin
                shreg   <= '0;
                bit_idx <= '0;
            end
            if (st == ST_DATA && dec) begin
                shreg[bit_idx] <= maj;
                bit_idx        <= bit_idx + 1'b1;
            end
            if (rd_ack) rx_full <= 1'b0;
            if (store) begin
                rx_data <= shreg;
                rx_full <= 1'b1;
                frm_err <= !maj;
                par_err <= perr;
            end
            if (brk_set)      brk_flag <= 1'b1;
            else if (brk_clr) brk_flag <= 1'b0;
        end
    end

    // R2
    full_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(st == ST_STOP));
    // R3
    good_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP && dec && maj) |=> (rx_full && !frm_err));
    // R5
    supp_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP && dec && brk_en && brk_hit) |=> ($stable(rx_data) && $stable(frm_err) && brk_flag));
    // R7
    brk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> $past(brk_en));
    // R8
    sticky_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && !brk_clr) |=> brk_flag);
endmodule

// File: tb/tb_uart_brk_rx.sv
module tb_uart_brk_rx;
    localparam int OVS = 16;
    localparam int NV  = 18;
    // [30]nine [29]par_en [28]par_odd [27]brk_en [26:18]data [17]stop [16:13]extra zeros
    // [12]exp_full [11:3]exp_data [2]exp_fe [1]exp_pe [0]exp_brk
    localparam logic [30:0] VECS [NV] = '{
        {4'b0001, 9'h055, 1'b1, 4'd0, 1'b1, 9'h055, 3'b000}, // R2
        {4'b0000, 9'h0A3, 1'b1, 4'd0, 1'b1, 9'h0A3, 3'b000}, // R2
        {4'b0101, 9'h003, 1'b1, 4'd0, 1'b1, 9'h003, 3'b000}, // R4
        {4'b0101, 9'h007, 1'b1, 4'd0, 1'b1, 9'h007, 3'b010}, // R4
        {4'b0111, 9'h007, 1'b1, 4'd0, 1'b1, 9'h007, 3'b000}, // R4
        {4'b1001, 9'h1A5, 1'b1, 4'd0, 1'b1, 9'h1A5, 3'b000}, // R2
        {4'b1111, 9'h100, 1'b1, 4'd0, 1'b1, 9'h100, 3'b000}, // R4
        {4'b0001, 9'h081, 1'b0, 4'd0, 1'b1, 9'h081, 3'b100}, // R3
        {4'b0001, 9'h000, 1'b0, 4'd0, 1'b0, 9'h081, 3'b101}, // R5
        {4'b0000, 9'h000, 1'b0, 4'd0, 1'b1, 9'h000, 3'b100}, // R7
        {4'b0110, 9'h000, 1'b0, 4'd0, 1'b1, 9'h000, 3'b110}, // R7
        {4'b0101, 9'h007, 1'b0, 4'd4, 1'b1, 9'h007, 3'b111}, // R6
        {4'b1001, 9'h000, 1'b0, 4'd0, 1'b0, 9'h007, 3'b111}, // R9
        {4'b1001, 9'h001, 1'b0, 4'd1, 1'b1, 9'h001, 3'b100}, // R9
        {4'b1001, 9'h001, 1'b0, 4'd2, 1'b1, 9'h001, 3'b101}, // R9
        {4'b0001, 9'h001, 1'b0, 4'd1, 1'b1, 9'h001, 3'b100}, // R6
        {4'b0001, 9'h001, 1'b0, 4'd2, 1'b1, 9'h001, 3'b101}, // R6
        {4'b1101, 9'h0FF, 1'b1, 4'd0, 1'b1, 9'h0FF, 3'b000}  // R3
    };

    logic clk = 1'b0, rst_n = 1'b0, samp_tick = 1'b0, rxd = 1'b1;
    logic nine_bit_sel = 1'b0, par_en = 1'b0, par_odd = 1'b0, brk_en = 1'b0;
    logic brk_clr = 1'b0, rd_ack = 1'b0;
    logic [8:0] rx_data;
    logic rx_full, frm_err, par_err, brk_flag;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(negedge clk) samp_tick <= ~samp_tick;

    uart_brk_rx dut (
        .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .rxd(rxd),
        .nine_bit_sel(nine_bit_sel), .par_en(par_en), .par_odd(par_odd),
        .brk_en(brk_en), .brk_clr(brk_clr), .rd_ack(rd_ack),
        .rx_data(rx_data), .rx_full(rx_full), .frm_err(frm_err),
        .par_err(par_err), .brk_flag(brk_flag)
    );

    function automatic string vtag(int i);
        case (i)
            2, 3, 4, 6: return "R4";
            7, 17:      return "R3";
            8:          return "R5";
            9, 10:      return "R7";
            11, 15, 16: return "R6";
            12, 13, 14: return "R9";
            default:    return "R2";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [8:0] act, logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one bit period = OVS ticks = 2*OVS clocks
    task automatic send_bit(logic b);
        rxd = b;
        repeat (2 * OVS) @(negedge clk);
    endtask

    task automatic send_frame(logic nine, logic [8:0] d, logic stp, int xz);
        send_bit(1'b0);
        for (int k = 0; k < (nine ? 9 : 8); k++) send_bit(d[k]);
        send_bit(stp);
        for (int k = 0; k < xz; k++) send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic clear_flags();
        @(negedge clk);
        rd_ack = 1'b1; brk_clr = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0; brk_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset state
        chk("R10", "rx_full", {8'h0, rx_full}, 9'h0);
        chk("R10", "rx_data", rx_data, 9'h0);
        chk("R10", "flags", {6'h0, frm_err, par_err, brk_flag}, 9'h0);
        rst_n = 1'b1;
        repeat (4 * OVS) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            logic [8:0]  pd;
            logic        pfe, ppe;
            v = VECS[i];
            nine_bit_sel = v[30]; par_en = v[29]; par_odd = v[28]; brk_en = v[27];
            clear_flags();
            pd = rx_data; pfe = frm_err; ppe = par_err;
            send_frame(v[30], v[26:18], v[17], int'(v[16:13]));
            chk(vtag(i), "rx_full", {8'h0, rx_full}, {8'h0, v[12]});
            chk(vtag(i), "brk_flag", {8'h0, brk_flag}, {8'h0, v[0]});
            if (v[12]) begin
                chk(vtag(i), "rx_data", rx_data, v[11:3]);
                chk(vtag(i), "frm_err", {8'h0, frm_err}, {8'h0, v[2]});
                chk(vtag(i), "par_err", {8'h0, par_err}, {8'h0, v[1]});
            end else begin
                chk(vtag(i), "rx_data kept", rx_data, pd);
                chk(vtag(i), "frm_err kept", {8'h0, frm_err}, {8'h0, pfe});
                chk(vtag(i), "par_err kept", {8'h0, par_err}, {8'h0, ppe});
            end
        end

        // R2 rd_ack clears full flag
        @(negedge clk); rd_ack = 1'b1;
        @(negedge clk); rd_ack = 1'b0;
        chk("R2", "rx_full after rd_ack", {8'h0, rx_full}, 9'h0);

        // R1 short low glitch is rejected, then a valid frame is taken
        nine_bit_sel = 1'b0; par_en = 1'b0; brk_en = 1'b1;
        clear_flags();
        rxd = 1'b0; repeat (8) @(negedge clk);
        send_bit(1'b1); send_bit(1'b1);
        chk("R1", "rx_full after glitch", {8'h0, rx_full}, 9'h0);
        send_frame(1'b0, 9'h05A, 1'b1, 0);
        chk("R1", "rx_data after glitch", rx_data, 9'h05A);

        // R8 sticky flag, single set per run, no hunting while low
        clear_flags();
        for (int k = 0; k < 12; k++) send_bit(1'b0);
        chk("R8", "brk_flag set", {8'h0, brk_flag}, 9'h1);
        send_bit(1'b0);
        chk("R8", "brk_flag sticky", {8'h0, brk_flag}, 9'h1);
        @(negedge clk); brk_clr = 1'b1;
        @(negedge clk); brk_clr = 1'b0;
        for (int k = 0; k < 12; k++) send_bit(1'b0);
        chk("R8", "brk_flag after clear in low run", {8'h0, brk_flag}, 9'h0);
        chk("R8", "no word while low", {8'h0, rx_full}, 9'h0);
        send_bit(1'b1); send_bit(1'b1);
        send_frame(1'b0, 9'h03C, 1'b1, 0);
        chk("R8", "word after line high", rx_data, 9'h03C);
        chk("R8", "rx_full after line high", {8'h0, rx_full}, 9'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule